// File: doc/BRIEF.md
# Exception Return Address Register Unit

This unit holds the two exception return address registers of a RISC-V style core: the machine-level one and the supervisor-level one. Software reaches them through a CSR port addressed by a 12-bit CSR number. Trap entry loads the faulting PC through a separate capture port. A return-target port gives the address that an xRET at the selected privilege level jumps to.

Legalization happens at two points. On a write, the CSR write or the trap capture, the low bits are cleared according to the static compressed-support parameter. On a read, the CSR read or the return target, the low bits are cleared according to the live compressed-enable input. When compressed support exists, bit 1 is therefore kept in storage while compressed execution is off. It appears again in reads once compressed execution is enabled.

Top module: `xepc_unit`

## Requirements
- R1: A synchronous active-high reset clears both registers to zero, so reads at CSR 0x341 and 0x141 return 0.
- R2: With HAS_COMPRESSED=1, a write stores the value with bit 0 cleared and bit 1 kept as written.
- R3: With HAS_COMPRESSED=0, a write stores the value with bits 1 and 0 both cleared.
- R4: When `misa_c` is 1, a read returns the stored value with only bit 0 cleared.
- R5: When `misa_c` is 0, a read returns the stored value with bits 1 and 0 cleared. A stored bit 1 is not lost and shows in reads again once `misa_c` returns to 1.
- R6: CSR address 0x341 selects the machine register and 0x141 selects the supervisor register. A write to one leaves the other unchanged.
- R7: An access (`csr_valid`=1) to any other address drives `csr_unhandled` to 1 and `csr_rdata` to 0, and changes neither register.
- R8: When `trap_valid` is 1, `trap_pc` is legalized as a write and loaded into the register selected by `trap_priv`, where 2'b11 selects machine and 2'b01 selects supervisor. In the same cycle, a trap capture wins over a CSR write to the same register.
- R9: `ret_target` equals the read-aligned value of the machine register for `ret_priv`=2'b11 and of the supervisor register for 2'b01, with no further masking. Any other `ret_priv` value (user 2'b00, or 2'b10) drives `ret_illegal` to 1 and `ret_target` to 0.
- R10: CSR reads are combinational. Writes and captures become visible after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| misa_c | input | 1 | Live compressed-instruction enable |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | XLEN | CSR write value |
| csr_rdata | output | XLEN | Read-aligned CSR value |
| csr_unhandled | output | 1 | Access to an address this unit does not own |
| trap_valid | input | 1 | Trap-entry capture strobe |
| trap_priv | input | 2 | Target privilege of the trap |
| trap_pc | input | XLEN | Faulting PC to capture |
| ret_priv | input | 2 | Privilege level of the xRET |
| ret_target | output | XLEN | xRET jump address |
| ret_illegal | output | 1 | xRET requested for a level without a register |

## Verification
The read side, `csr_rdata`, `csr_unhandled`, `ret_target` and `ret_illegal`, is combinational. It is due in the same cycle as the address, the privilege or `misa_c` changes. The bench checks it one time step after it drives those inputs at the falling edge. A write or trap capture is due one rising edge after it is driven. The bench first checks that the old value is still read before the edge, then checks the new value one step after the edge.

// File: rtl/xepc_pkg.sv
package xepc_pkg;

    localparam logic [11:0] CSR_MEPC_ADDR = 12'h341;
    localparam logic [11:0] CSR_SEPC_ADDR = 12'h141;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

endpackage

// File: rtl/xepc_write_legal.sv
module xepc_write_legal #(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] legal
);
    localparam int CLR_BITS = HAS_COMPRESSED ? 1 : 2;

    generate
        if (CLR_BITS == 1) begin : g_half_align
            assign legal = {raw[XLEN-1:1], 1'b0};
        end else begin : g_word_align
            assign legal = {raw[XLEN-1:2], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/xepc_read_align.sv
module xepc_read_align #(
    parameter int XLEN = 32
) (
    input  logic            c_on,
    input  logic [XLEN-1:0] stored,
    output logic [XLEN-1:0] aligned
);
    always_comb begin
        aligned    = stored;
        aligned[0] = 1'b0;
        if (!c_on) begin
            aligned[1] = 1'b0;
        end
    end
endmodule

// File: rtl/xepc_unit.sv
module xepc_unit
    import xepc_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            misa_c,
    input  logic            csr_valid,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_unhandled,
    input  logic            trap_valid,
    input  logic [1:0]      trap_priv,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [1:0]      ret_priv,
    output logic [XLEN-1:0] ret_target,
    output logic            ret_illegal
);
    localparam int NREG   = 2;
    localparam int IDX_M  = 0;
    localparam int IDX_S  = 1;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] epc;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] csr_legal, trap_legal;
    logic [NREG-1:0][XLEN-1:0] epc_aligned;
    logic hit_m, hit_s;
    logic [NREG-1:0] csr_wr_sel, trap_sel;

    xepc_write_legal #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_csr_legal (
        .raw   (csr_wdata),
        .legal (csr_legal)
    );

    xepc_write_legal #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_trap_legal (
        .raw   (trap_pc),
        .legal (trap_legal)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_align
            xepc_read_align #(.XLEN(XLEN)) u_align (
                .c_on    (misa_c),
                .stored  (st_q.epc[i]),
                .aligned (epc_aligned[i])
            );
        end
    endgenerate

    always_comb begin
        hit_m = (csr_addr == CSR_MEPC_ADDR);
        hit_s = (csr_addr == CSR_SEPC_ADDR);

        csr_wr_sel        = '0;
        csr_wr_sel[IDX_M] = csr_valid && csr_we && hit_m;
        csr_wr_sel[IDX_S] = csr_valid && csr_we && hit_s;

        trap_sel        = '0;
        trap_sel[IDX_M] = trap_valid && (trap_priv == PRIV_MACH);
        trap_sel[IDX_S] = trap_valid && (trap_priv == PRIV_SUPER);

        csr_unhandled = csr_valid && !(hit_m || hit_s);
        if (hit_m) begin
            csr_rdata = epc_aligned[IDX_M];
        end else if (hit_s) begin
            csr_rdata = epc_aligned[IDX_S];
        end else begin
            csr_rdata = '0;
        end

        ret_illegal = 1'b0;
        unique case (priv_e'(ret_priv))
            PRIV_MACH:  ret_target = epc_aligned[IDX_M];
            PRIV_SUPER: ret_target = epc_aligned[IDX_S];
            default: begin
                ret_target  = '0;
                ret_illegal = 1'b1;
            end
        endcase

        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (csr_wr_sel[i]) begin
                st_d.epc[i] = csr_legal;
            end
            if (trap_sel[i]) begin
                st_d.epc[i] = trap_legal;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/xepc_unit_chk.sv
module xepc_unit_chk
    import xepc_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            misa_c,
    input logic            csr_valid,
    input logic            csr_we,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_unhandled,
    input logic            trap_valid,
    input logic [1:0]      trap_priv,
    input logic [XLEN-1:0] trap_pc,
    input logic [1:0]      ret_priv,
    input logic [XLEN-1:0] ret_target,
    input logic            ret_illegal
);
    localparam logic [XLEN-1:0] WMASK = HAS_COMPRESSED ? ~XLEN'(1) : ~XLEN'(3);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ret_priv == PRIV_MACH) |-> ret_target == '0);

    // R4
    read_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && !csr_unhandled) |-> csr_rdata[0] == 1'b0);

    // R5
    read_word_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && !csr_unhandled && !misa_c) |-> csr_rdata[1:0] == 2'b00);

    // R7
    unhandled_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_addr != CSR_MEPC_ADDR && csr_addr != CSR_SEPC_ADDR)
        |-> (csr_unhandled && csr_rdata == '0));

    // R9
    ret_match_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_priv == PRIV_MACH && csr_addr == CSR_MEPC_ADDR) |-> ret_target == csr_rdata);

    // R9
    ret_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_priv == PRIV_USER) |-> (ret_illegal && ret_target == '0));

    // R10
    write_next_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(csr_valid && csr_we && csr_addr == CSR_MEPC_ADDR && !trap_valid)
         && misa_c && ret_priv == PRIV_MACH)
        |-> ret_target == ($past(csr_wdata) & WMASK));

    // R8
    trap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trap_valid && trap_priv == PRIV_MACH)
         && misa_c && ret_priv == PRIV_MACH)
        |-> ret_target == ($past(trap_pc) & WMASK));
endmodule

bind xepc_unit xepc_unit_chk #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_chk (.*);

// File: tb/xepc_unit_bench.sv
module xepc_unit_bench;
    localparam int XLEN = 32;
    localparam logic [11:0] A_M = 12'h341;
    localparam logic [11:0] A_S = 12'h141;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic misa_c = 1'b1;
    logic csr_valid = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = A_M;
    logic [XLEN-1:0] csr_wdata = '0;
    logic trap_valid = 1'b0;
    logic [1:0] trap_priv = 2'b11;
    logic [XLEN-1:0] trap_pc = '0;
    logic [1:0] ret_priv = 2'b11;

    logic [XLEN-1:0] rdata_c, rdata_n, rtgt_c, rtgt_n;
    logic unh_c, unh_n, rill_c, rill_n;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    xepc_unit #(.XLEN(XLEN), .HAS_COMPRESSED(1'b1)) u_xepc_unit (
        .clk(clk), .rst(rst), .misa_c(misa_c), .csr_valid(csr_valid), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata_c),
        .csr_unhandled(unh_c), .trap_valid(trap_valid), .trap_priv(trap_priv),
        .trap_pc(trap_pc), .ret_priv(ret_priv), .ret_target(rtgt_c), .ret_illegal(rill_c));

    xepc_unit #(.XLEN(XLEN), .HAS_COMPRESSED(1'b0)) u_xepc_unit_nc (
        .clk(clk), .rst(rst), .misa_c(1'b0), .csr_valid(csr_valid), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata_n),
        .csr_unhandled(unh_n), .trap_valid(trap_valid), .trap_priv(trap_priv),
        .trap_pc(trap_pc), .ret_priv(ret_priv), .ret_target(rtgt_n), .ret_illegal(rill_n));

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_c(logic [11:0] a, logic [XLEN-1:0] exp, string req);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1 check(req, rdata_c, exp);
        csr_valid = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [XLEN-1:0] v);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = v;
        @(posedge clk); #1;
        csr_valid = 1'b0; csr_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd_c(A_M, '0, "R1 mepc");
        rd_c(A_S, '0, "R1 sepc");
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = A_M; csr_wdata = 32'h8000_0003;
        #1 check("R10 before edge", rdata_c, '0);
        @(posedge clk); #1;
        check("R10 after edge", rdata_c, 32'h8000_0002);
        csr_valid = 1'b0; csr_we = 1'b0;
    endtask

    task automatic t_legalize();
        rd_c(A_M, 32'h8000_0002, "R2 R4 bit1 kept");
        @(negedge clk); csr_valid = 1'b1; csr_addr = A_M;
        #1 check("R3 no-compressed write", rdata_n, 32'h8000_0000);
        csr_valid = 1'b0;
    endtask

    task automatic t_misa_toggle();
        misa_c = 1'b0;
        rd_c(A_M, 32'h8000_0000, "R5 masked read");
        misa_c = 1'b1;
        rd_c(A_M, 32'h8000_0002, "R5 bit1 returns");
    endtask

    task automatic t_independent();
        wr(A_S, 32'h1234_5677);
        rd_c(A_S, 32'h1234_5676, "R6 sepc");
        rd_c(A_M, 32'h8000_0002, "R6 mepc untouched");
    endtask

    task automatic t_unhandled();
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = 12'h300; csr_wdata = '1;
        #1 check("R7 unhandled flag", XLEN'(unh_c), XLEN'(1));
        check("R7 zero data", rdata_c, '0);
        @(posedge clk); #1;
        csr_valid = 1'b0; csr_we = 1'b0;
        rd_c(A_M, 32'h8000_0002, "R7 mepc unchanged");
        rd_c(A_S, 32'h1234_5676, "R7 sepc unchanged");
        @(negedge clk); csr_valid = 1'b1; csr_addr = A_M;
        #1 check("R7 handled flag low", XLEN'(unh_c), '0);
        csr_valid = 1'b0;
    endtask

    task automatic t_trap();
        @(negedge clk);
        trap_valid = 1'b1; trap_priv = 2'b11; trap_pc = 32'h4000_0006;
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = A_M; csr_wdata = 32'h1111_1110;
        @(posedge clk); #1;
        trap_valid = 1'b0; csr_valid = 1'b0; csr_we = 1'b0;
        rd_c(A_M, 32'h4000_0006, "R8 trap wins");
        @(negedge clk);
        trap_valid = 1'b1; trap_priv = 2'b01; trap_pc = 32'hABCD_EF03;
        @(posedge clk); #1 trap_valid = 1'b0;
        rd_c(A_S, 32'hABCD_EF02, "R8 trap sepc");
        @(negedge clk); csr_valid = 1'b1; csr_addr = A_S;
        #1 check("R8 no-compressed trap", rdata_n, 32'hABCD_EF00);
        csr_valid = 1'b0;
    endtask

    task automatic t_ret();
        @(negedge clk);
        ret_priv = 2'b11;
        #1 check("R9 ret mepc", rtgt_c, 32'h4000_0006);
        misa_c = 1'b0;
        #1 check("R9 ret mepc masked", rtgt_c, 32'h4000_0004);
        ret_priv = 2'b01;
        #1 check("R9 ret sepc", rtgt_c, 32'hABCD_EF00);
        misa_c = 1'b1;
        ret_priv = 2'b00;
        #1 check("R9 user illegal", XLEN'(rill_c), XLEN'(1));
        check("R9 user target", rtgt_c, '0);
        ret_priv = 2'b10;
        #1 check("R9 rsvd illegal", XLEN'(rill_c), XLEN'(1));
        ret_priv = 2'b11;
        #1 check("R9 legal flag low", XLEN'(rill_c), '0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write_timing();
        t_legalize();
        t_misa_toggle();
        t_independent();
        t_unhandled();
        t_trap();
        t_ret();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule